// File: doc/BRIEF.md
# Delayed Bus Parity Generator and Checker

This block generates and checks even parity for one or more multiplexed address/data buses, each with a 32-bit data path and four command/byte-enable lines. On a parity bus the parity bit trails the values it covers by one clock. The block therefore registers what it needs from each covered cycle and pairs it with the parity of the following cycle. One lane is built per port. The default build has three lanes: one for the primary port and one for each of two secondary ports.

When a port drives the bus, its lane takes the data and byte-enable values being driven and presents their parity one clock later. It also raises the parity output enable one clock after the data output enable. When a port receives, a qualifier input from the bus state machine marks the cycles that must be checked, which are address phases and write data phases. The lane folds the sampled data and byte enables into one expected-parity bit and registers it together with the qualifier. In the next cycle it compares that bit with the incoming parity line and raises a one-cycle error pulse if the count of ones is odd. Error logging, system-error policy and the bus state machines live outside this block.

Top module: `bus_parity_unit`

## Requirements
- R1: While rst_ni is low, par_oe_o and perr_o are all zero and par_o is zero for every lane.
- R2: par_o[k] in cycle n+1 equals the XOR of all bits of ad_tx_i and be_tx_i for lane k in cycle n, so that the 32 data bits, the 4 byte-enable bits and the parity bit together hold an even number of ones.
- R3: par_oe_o[k] in cycle n+1 equals ad_oe_i[k] in cycle n.
- R4: If chk_i[k] is high in cycle n, perr_o[k] is high in cycle n+1 exactly when the lane's ad_rx_i and be_rx_i of cycle n and par_rx_i[k] of cycle n+1 together hold an odd number of ones.
- R5: If chk_i[k] is low in cycle n (idle, turnaround or a read data phase the port itself mastered), perr_o[k] is low in cycle n+1 whatever the parity.
- R6: perr_o[k] is a single-cycle pulse per failing phase: it is low in the cycle after an error unless the following phase was also checked and also failed.
- R7: Lanes are independent. A parity error on one lane raises perr_o only for that lane.
- R8: In back-to-back checked phases, each phase is judged against the parity sampled in the cycle directly after it, with no carry-over from earlier phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ad_tx_i | input | NUM_PORTS*AD_W | Data/address driven by each lane, lane k at bits [k*AD_W +: AD_W] |
| be_tx_i | input | NUM_PORTS*BE_W | Command/byte enables driven by each lane |
| ad_oe_i | input | NUM_PORTS | Data output enable per lane |
| par_o | output | NUM_PORTS | Generated parity, one clock behind the data it covers |
| par_oe_o | output | NUM_PORTS | Parity output enable, ad_oe_i delayed one clock |
| ad_rx_i | input | NUM_PORTS*AD_W | Data/address sampled from each bus |
| be_rx_i | input | NUM_PORTS*BE_W | Command/byte enables sampled from each bus |
| chk_i | input | NUM_PORTS | Marks an address or write-data phase to be checked |
| par_rx_i | input | NUM_PORTS | Parity line sampled from each bus |
| perr_o | output | NUM_PORTS | Parity error pulse, in the cycle the failing parity is sampled |

## Verification
Generation of a new parity and judgement of the previous phase's parity often happen in the same cycle on one lane, because a port that turns from receiving to driving reuses the same clock. The bench drives a transmit pattern and a receive pattern on every lane in every cycle, with the output enable, the qualifier and injected parity faults chosen at random. In each cycle it compares par_o, par_oe_o and perr_o against a behavioural model that remembers the previous cycle's stimulus. Directed sequences cover the cases most likely to expose a wrong alignment: a fault on one lane while the others are clean, a failed phase followed by an unchecked cycle, and runs of back-to-back checked phases with alternating faults.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int unsigned FOLD_W = 8;

  typedef struct packed {
    logic chk;
    logic odd;
  } rx_cap_t;

  function automatic int unsigned n_chunks(int unsigned w);
    return (w + FOLD_W - 1) / FOLD_W;
  endfunction
endpackage

// File: rtl/bpar_fold.sv
module bpar_fold
  import bpar_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] bits_i,
  output logic         odd_o
);
  localparam int unsigned NCH   = n_chunks(W);
  localparam int unsigned PAD_W = NCH * FOLD_W;

  logic [PAD_W-1:0] padded;
  logic [NCH-1:0]   chunk_odd;

  always_comb begin
    padded = '0;
    padded[W-1:0] = bits_i;
  end

  // byte-wide XOR leaves, then one XOR across the leaves
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    assign chunk_odd[c] = ^padded[c*FOLD_W +: FOLD_W];
  end

  assign odd_o = ^chunk_odd;
endmodule

// File: rtl/bpar_tx.sv
module bpar_tx #(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] be_i,
  input  logic            oe_i,
  output logic            par_o,
  output logic            par_oe_o
);
  localparam int unsigned COV_W = AD_W + BE_W;

  logic odd;

  bpar_fold #(.W(COV_W)) u_fold (
    .bits_i ({be_i, ad_i}),
    .odd_o  (odd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= odd;
      par_oe_o <= oe_i;
    end
  end
endmodule

// File: rtl/bpar_rx.sv
module bpar_rx
  import bpar_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] be_i,
  input  logic            chk_i,
  input  logic            par_i,
  output logic            perr_o
);
  localparam int unsigned COV_W = AD_W + BE_W;

  logic    odd;
  rx_cap_t cap_q;

  bpar_fold #(.W(COV_W)) u_fold (
    .bits_i ({be_i, ad_i}),
    .odd_o  (odd)
  );

  // fold before the flop: one bit of state instead of COV_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else begin
      cap_q.chk <= chk_i;
      cap_q.odd <= odd;
    end
  end

  assign perr_o = cap_q.chk & (cap_q.odd ^ par_i);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned AD_W      = 32,
  parameter int unsigned BE_W      = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS*AD_W-1:0] ad_tx_i,
  input  logic [NUM_PORTS*BE_W-1:0] be_tx_i,
  input  logic [NUM_PORTS-1:0]      ad_oe_i,
  output logic [NUM_PORTS-1:0]      par_o,
  output logic [NUM_PORTS-1:0]      par_oe_o,
  input  logic [NUM_PORTS*AD_W-1:0] ad_rx_i,
  input  logic [NUM_PORTS*BE_W-1:0] be_rx_i,
  input  logic [NUM_PORTS-1:0]      chk_i,
  input  logic [NUM_PORTS-1:0]      par_rx_i,
  output logic [NUM_PORTS-1:0]      perr_o
);
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_lane
    bpar_tx #(.AD_W(AD_W), .BE_W(BE_W)) u_tx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ad_i     (ad_tx_i[k*AD_W +: AD_W]),
      .be_i     (be_tx_i[k*BE_W +: BE_W]),
      .oe_i     (ad_oe_i[k]),
      .par_o    (par_o[k]),
      .par_oe_o (par_oe_o[k])
    );

    bpar_rx #(.AD_W(AD_W), .BE_W(BE_W)) u_rx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ad_i   (ad_rx_i[k*AD_W +: AD_W]),
      .be_i   (be_rx_i[k*BE_W +: BE_W]),
      .chk_i  (chk_i[k]),
      .par_i  (par_rx_i[k]),
      .perr_o (perr_o[k])
    );
  end
endmodule

// File: rtl/bus_parity_unit_chk.sv
module bus_parity_unit_chk #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned AD_W      = 32,
  parameter int unsigned BE_W      = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_PORTS*AD_W-1:0] ad_tx_i,
  input logic [NUM_PORTS*BE_W-1:0] be_tx_i,
  input logic [NUM_PORTS-1:0]      ad_oe_i,
  input logic [NUM_PORTS-1:0]      par_o,
  input logic [NUM_PORTS-1:0]      par_oe_o,
  input logic [NUM_PORTS*AD_W-1:0] ad_rx_i,
  input logic [NUM_PORTS*BE_W-1:0] be_rx_i,
  input logic [NUM_PORTS-1:0]      chk_i,
  input logic [NUM_PORTS-1:0]      par_rx_i,
  input logic [NUM_PORTS-1:0]      perr_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (par_oe_o == '0 && perr_o == '0 && par_o == '0));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_lane
    p_par_gen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (par_o[k] == ^{$past(ad_tx_i[k*AD_W +: AD_W]),
                                 $past(be_tx_i[k*BE_W +: BE_W])}));

    p_oe_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (par_oe_o[k] == $past(ad_oe_i[k])));

    p_perr_detect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(chk_i[k])) |->
        (perr_o[k] == ^{$past(ad_rx_i[k*AD_W +: AD_W]),
                        $past(be_rx_i[k*BE_W +: BE_W]), par_rx_i[k]}));

    p_perr_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !$past(chk_i[k])) |-> !perr_o[k]);
  end
endmodule

bind bus_parity_unit bus_parity_unit_chk #(
  .NUM_PORTS (NUM_PORTS),
  .AD_W      (AD_W),
  .BE_W      (BE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ad_tx_i  (ad_tx_i),
  .be_tx_i  (be_tx_i),
  .ad_oe_i  (ad_oe_i),
  .par_o    (par_o),
  .par_oe_o (par_oe_o),
  .ad_rx_i  (ad_rx_i),
  .be_rx_i  (be_rx_i),
  .chk_i    (chk_i),
  .par_rx_i (par_rx_i),
  .perr_o   (perr_o)
);

// File: tb/bus_parity_unit_tb_top.sv
`timescale 1ns/1ps
module bus_parity_unit_tb_top;
  localparam int NP = 3;
  localparam int AW = 32;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP*AW-1:0] ad_tx, ad_rx;
  logic [NP*BW-1:0] be_tx, be_rx;
  logic [NP-1:0]    oe, chk, par_rx;
  logic [NP-1:0]    par_o, par_oe_o, perr_o;

  bus_parity_unit #(.NUM_PORTS(NP), .AD_W(AW), .BE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ad_tx_i(ad_tx), .be_tx_i(be_tx), .ad_oe_i(oe),
    .par_o(par_o), .par_oe_o(par_oe_o),
    .ad_rx_i(ad_rx), .be_rx_i(be_rx), .chk_i(chk), .par_rx_i(par_rx),
    .perr_o(perr_o)
  );

  // stimulus per lane
  logic [AW-1:0] s_tad[NP], s_rad[NP];
  logic [BW-1:0] s_tbe[NP], s_rbe[NP];
  logic          s_oe[NP], s_chk[NP], s_inj[NP];
  // previous cycle, for the model
  logic [AW-1:0] p_tad[NP], p_rad[NP];
  logic [BW-1:0] p_tbe[NP], p_rbe[NP];
  logic          p_oe[NP], p_chk[NP];

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  function automatic logic odd_of(logic [AW-1:0] a, logic [BW-1:0] b);
    return logic'(($countones(a) + $countones(b)) % 2);
  endfunction

  task automatic check(string req, int lane, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane %0d: got %0b expected %0b at %0t", req, lane, act, exp, $time);
    end
  endtask

  task automatic clear_stim();
    for (int p = 0; p < NP; p++) begin
      s_tad[p] = '0; s_tbe[p] = '0; s_oe[p] = 0;
      s_rad[p] = '0; s_rbe[p] = '0; s_chk[p] = 0; s_inj[p] = 0;
      p_tad[p] = '0; p_tbe[p] = '0; p_oe[p] = 0;
      p_rad[p] = '0; p_rbe[p] = '0; p_chk[p] = 0;
    end
  endtask

  task automatic drive();
    for (int p = 0; p < NP; p++) begin
      ad_tx[p*AW +: AW] = s_tad[p];
      be_tx[p*BW +: BW] = s_tbe[p];
      oe[p]             = s_oe[p];
      ad_rx[p*AW +: AW] = s_rad[p];
      be_rx[p*BW +: BW] = s_rbe[p];
      chk[p]            = s_chk[p];
      // parity line: correct for the previous phase unless a fault is injected
      par_rx[p]         = odd_of(p_rad[p], p_rbe[p]) ^ s_inj[p];
    end
  endtask

  // one bus cycle: apply at negedge, judge 1 ns later, then shift history
  task automatic cycle(string perr_tag);
    @(negedge clk);
    drive();
    #1;
    for (int p = 0; p < NP; p++) begin
      logic exp_err;
      exp_err = p_chk[p] & logic'(($countones(p_rad[p]) + $countones(p_rbe[p]) + par_rx[p]) % 2);
      check("R2", p, par_o[p], odd_of(p_tad[p], p_tbe[p]));
      check("R3", p, par_oe_o[p], p_oe[p]);
      if (perr_tag != "") check(perr_tag, p, perr_o[p], exp_err);
      else if (p_chk[p])  check("R4", p, perr_o[p], exp_err);
      else                check("R5", p, perr_o[p], exp_err);
    end
    for (int p = 0; p < NP; p++) begin
      p_tad[p] = s_tad[p]; p_tbe[p] = s_tbe[p]; p_oe[p] = s_oe[p];
      p_rad[p] = s_rad[p]; p_rbe[p] = s_rbe[p]; p_chk[p] = s_chk[p];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    clear_stim();
    // R1: busy inputs while reset is held
    for (int p = 0; p < NP; p++) begin
      s_tad[p] = '1; s_tbe[p] = 4'h7; s_oe[p] = 1; s_rad[p] = 32'h1; s_chk[p] = 1; s_inj[p] = 1;
    end
    drive();
    repeat (3) @(negedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      check("R1", p, par_o[p], 1'b0);
      check("R1", p, par_oe_o[p], 1'b0);
      check("R1", p, perr_o[p], 1'b0);
    end
    @(negedge clk);
    clear_stim();
    drive();
    rst_ni = 1'b1;

    // R2/R4: all ones (36 ones, even) then a clean and a faulty phase
    for (int p = 0; p < NP; p++) begin
      s_tad[p] = '1; s_tbe[p] = '1; s_oe[p] = 1;
      s_rad[p] = '1; s_rbe[p] = '1; s_chk[p] = 1;
    end
    cycle("");
    for (int p = 0; p < NP; p++) begin
      s_tad[p] = 32'h0000_0001; s_tbe[p] = 4'h0; s_rad[p] = 32'h8000_0000; s_rbe[p] = 4'h1;
    end
    cycle("R4");
    for (int p = 0; p < NP; p++) begin s_inj[p] = 1; s_chk[p] = 0; s_oe[p] = 0; end
    cycle("R4");  // faulty parity on a checked phase
    // R6: cycle after the pulse, qualifier was low
    for (int p = 0; p < NP; p++) s_inj[p] = 0;
    cycle("R6");
    // R5: unchecked phase with a wrong parity line
    for (int p = 0; p < NP; p++) begin s_chk[p] = 0; s_rad[p] = 32'h0000_0007; end
    cycle("R5");
    for (int p = 0; p < NP; p++) s_inj[p] = 1;
    cycle("R5");
    // R7: fault on lane 0 only
    for (int p = 0; p < NP; p++) begin s_inj[p] = 0; s_chk[p] = 1; s_rad[p] = 32'hA5A5_0F0F; end
    cycle("R7");
    s_inj[0] = 1;
    for (int p = 0; p < NP; p++) s_chk[p] = 0;
    cycle("R7");
    // R8: back-to-back checked phases with alternating faults
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < NP; p++) begin
        s_chk[p] = 1;
        s_rad[p] = 32'h1357_9BDF ^ (32'(i) << p);
        s_rbe[p] = 4'(i + p);
        s_inj[p] = logic'((i + p) % 2);
      end
      cycle("R8");
    end

    // random traffic: generation and checking together on every lane
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NP; p++) begin
        s_tad[p] = $urandom; s_tbe[p] = 4'($urandom);
        s_rad[p] = $urandom; s_rbe[p] = 4'($urandom);
        s_oe[p]  = 1'($urandom);
        s_chk[p] = 1'($urandom);
        s_inj[p] = ($urandom % 4) == 0;
      end
      cycle("");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule